// File: doc/BRIEF.md
# Parallel Host Bus Slave Port

This block lets an external processor reach a small on-chip register bank over an asynchronous parallel bus that uses separate read and write strobes plus an active-low chip select. A static mode pin picks one of two bus layouts. In the split layout, address and data arrive on their own pins and the address-latch strobe is tied high. In the shared layout, the address is driven on the data pins first and is captured when the address-latch strobe falls. The data pins are then used for data.

Every host pin is brought into the internal clock through a two-stage synchroniser. The block turns each host access into exactly one single-cycle request toward the register bank. A read request fires when a read access begins. A write request fires when the write strobe returns high, and it carries the data that was on the bus just before that edge. During a read, the block captures the bank's answer and drives it back through a tri-state data bus, given here as separate out and enable pins. At all other times the data bus is released.

Top module: `hostbus_port`

## Requirements
- R1: While reset is held, `reg_wr`, `reg_rd` and `data_oe` are all 0.
- R2: With `mux_sel` = 0, one write access (`cs_n` low, `rd_n` high, `wr_n` low then high) produces exactly one `reg_wr` pulse one cycle wide. Its `reg_addr` equals `addr_pins` and its `reg_wdata` equals `data_in` as held during the strobe.
- R3: With `mux_sel` = 1, the address is taken from the low address-width bits of `data_in` at the falling edge of `ale`. It stays in force for every following access until the next falling edge of `ale`.
- R4: A read access (`cs_n` low, `wr_n` high, `rd_n` low) produces exactly one `reg_rd` pulse one cycle wide at its start. The pulse carries the address selected by the current mode.
- R5: `data_oe` is 1 only while a read access that has already issued its `reg_rd` is still in progress. Meanwhile `data_out` shows the `reg_rdata` value sampled during that `reg_rd` pulse. `data_oe` returns to 0 within four cycles after the access ends.
- R6: While `cs_n` is high, toggling `rd_n` or `wr_n` produces no `reg_rd`, no `reg_wr`, and no `data_oe`.
- R7: While both strobes are low together, neither access type is recognised, so no request is issued. `reg_rd` and `reg_wr` are never high in the same cycle.
- R8: With `mux_sel` = 1, the value on `addr_pins` has no effect on `reg_addr`.
- R9: `reg_wdata` is the bus value in the last sample before the write strobe rises. Earlier values that were present while the strobe was low are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| mux_sel | input | 1 | 0 = split address/data pins, 1 = shared bus with address latch |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address-latch strobe, address taken on its falling edge |
| addr_pins | input | AW | Address pins, used in split mode |
| data_in | input | DW | Data bus as driven by the host |
| data_out | output | DW | Data bus value driven by the block |
| data_oe | output | 1 | Data bus output enable |
| reg_addr | output | AW | Register address for the bank |
| reg_wdata | output | DW | Write data for the bank |
| reg_wr | output | 1 | One-cycle write request |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | DW | Read data returned by the bank |

## Verification
A synchroniser stage that is skipped or misaligned shows up at the ports as the wrong address or data on a request, within about four clock cycles of the host edge. It appears as a latched shared-bus address that already holds the data phase, or as write data taken from an earlier bus value. A broken "read already served" flag produces duplicate or missing `reg_rd` pulses, or an enable that stays high after the strobe releases. The scoreboard catches each of these on the very next request, or it finds a queue that is not empty at the end. Faulty cycle decoding appears as requests issued while chip select is high or while both strobes are low.

// File: rtl/hostbus_port.sv
module hostbus_port #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_sel,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ale,
  input  logic [AW-1:0] addr_pins,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);

  localparam int SW = 4;
  localparam logic [SW-1:0] STB_IDLE = 4'b0111;

  // strobe pipeline: {ale, cs_n, rd_n, wr_n}
  logic [SW-1:0] stb1, stb2, stb3;
  logic [DW-1:0] dat1, dat2, dat3;
  logic [AW-1:0] adr1, adr2, adr3;
  logic [AW-1:0] addr_latch;
  logic [DW-1:0] rd_hold;
  logic          rd_done;
  logic          oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb1 <= STB_IDLE;
      stb2 <= STB_IDLE;
      stb3 <= STB_IDLE;
      dat1 <= '0;
      dat2 <= '0;
      dat3 <= '0;
      adr1 <= '0;
      adr2 <= '0;
      adr3 <= '0;
    end else begin
      stb1 <= {ale, cs_n, rd_n, wr_n};
      stb2 <= stb1;
      stb3 <= stb2;
      dat1 <= data_in;
      dat2 <= dat1;
      dat3 <= dat2;
      adr1 <= addr_pins;
      adr2 <= adr1;
      adr3 <= adr2;
    end
  end

  wire ale2 = stb2[3];
  wire ale3 = stb3[3];
  wire cs2  = stb2[2];
  wire cs3  = stb3[2];
  wire rd2  = stb2[1];
  wire rd3  = stb3[1];
  wire wr2  = stb2[0];
  wire wr3  = stb3[0];

  wire rd_act2  = ~cs2 & ~rd2 & wr2;
  wire wr_act3  = ~cs3 & ~wr3 & rd3;
  wire ale_fall = ale3 & ~ale2;
  wire wr_end   = wr_act3 & wr2;
  wire rd_start = rd_act2 & ~rd_done & ~wr_end;

  wire [AW-1:0] bus_addr = dat3[AW-1:0];
  wire [AW-1:0] wr_addr  = mux_sel ? addr_latch : adr3;
  wire [AW-1:0] rd_addr  = mux_sel ? addr_latch : adr2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_latch <= '0;
    else if (ale_fall) addr_latch <= bus_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rd_done   <= 1'b0;
    end else begin
      reg_wr  <= wr_end;
      reg_rd  <= rd_start;
      rd_done <= rd_act2 & (rd_done | rd_start);
      if (wr_end) begin
        reg_addr  <= wr_addr;
        reg_wdata <= dat3;
      end else if (rd_start) begin
        reg_addr <= rd_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (reg_rd) rd_hold <= reg_rdata;
      oe_q <= rd_done & rd_act2;
    end
  end

  assign data_out = rd_hold;
  assign data_oe  = oe_q;

  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_oe_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(reg_rd));

  assert_oe_only_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> rd_done);

  assert_no_dual_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

endmodule

// File: tb/test_hostbus_port.sv
module test_hostbus_port;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mux_sel = 1'b0;
  logic          cs_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic          ale = 1'b1;
  logic [AW-1:0] addr_pins = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic          data_oe;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic          reg_wr;
  logic          reg_rd;
  logic [DW-1:0] reg_rdata;

  int total = 0;
  int bad = 0;

  logic [AW+DW-1:0] wr_q[$];
  logic [AW-1:0]    rd_q[$];

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] bank_val(input logic [AW-1:0] a);
    return {a[3:0], a[7:4]} ^ 8'hC3;
  endfunction

  assign reg_rdata = bank_val(reg_addr);

  hostbus_port #(.AW(AW), .DW(DW)) i_hostbus_port (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .ale(ale), .addr_pins(addr_pins), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected requests as the design issues them
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin
        if (wr_q.size() == 0) check(1'b0, "R6 R7 unexpected write", reg_addr, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = wr_q.pop_front();
          check({reg_addr, reg_wdata} == e, "R2 R3 R8 R9 write", {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_rd) begin
        if (rd_q.size() == 0) check(1'b0, "R4 R6 R7 unexpected read", reg_addr, 0);
        else begin
          logic [AW-1:0] e;
          e = rd_q.pop_front();
          check(reg_addr == e, "R4 read address", reg_addr, e);
        end
      end
    end
  end

  task automatic latch_addr(input logic [AW-1:0] a);
    data_in = a;
    ale = 1'b1;
    cyc(4);
    ale = 1'b0;
    cyc(4);
    data_in = 8'h00;
  endtask

  task automatic host_write(input logic [AW-1:0] exp_a, input logic [DW-1:0] d,
                            input logic [AW-1:0] pins);
    wr_q.push_back({exp_a, d});
    addr_pins = pins;
    cs_n = 1'b0;
    cyc(3);
    data_in = ~d;
    wr_n = 1'b0;
    cyc(4);
    data_in = d;
    cyc(4);
    wr_n = 1'b1;
    cyc(3);
    cs_n = 1'b1;
    data_in = ~d;
    cyc(4);
  endtask

  task automatic host_read(input logic [AW-1:0] exp_a, input logic [AW-1:0] pins);
    rd_q.push_back(exp_a);
    addr_pins = pins;
    cs_n = 1'b0;
    cyc(3);
    rd_n = 1'b0;
    cyc(8);
    check(data_oe == 1'b1, "R5 oe during read", data_oe, 1);
    check(data_out == bank_val(exp_a), "R5 read data", data_out, bank_val(exp_a));
    rd_n = 1'b1;
    cs_n = 1'b1;
    cyc(5);
    check(data_oe == 1'b0, "R5 oe released", data_oe, 0);
  endtask

  initial begin
    cyc(3);
    check(reg_wr == 1'b0, "R1 reg_wr in reset", reg_wr, 0);
    check(reg_rd == 1'b0, "R1 reg_rd in reset", reg_rd, 0);
    check(data_oe == 1'b0, "R1 data_oe in reset", data_oe, 0);
    rst_n = 1'b1;
    cyc(5);

    // split mode, R2 and R9
    host_write(8'h12, 8'hA5, 8'h12);
    host_write(8'hFF, 8'h00, 8'hFF);
    host_write(8'h00, 8'hFF, 8'h00);
    // R4 and R5
    host_read(8'h34, 8'h34);
    host_read(8'hC0, 8'hC0);

    // R6: strobes with chip select high
    addr_pins = 8'h77;
    data_in = 8'h99;
    wr_n = 1'b0;
    cyc(6);
    wr_n = 1'b1;
    cyc(4);
    rd_n = 1'b0;
    cyc(6);
    check(data_oe == 1'b0, "R6 oe with cs high", data_oe, 0);
    rd_n = 1'b1;
    cyc(6);

    // R7: both strobes low together
    cs_n = 1'b0;
    cyc(3);
    rd_n = 1'b0;
    wr_n = 1'b0;
    cyc(8);
    check(data_oe == 1'b0, "R7 oe with both strobes", data_oe, 0);
    rd_n = 1'b1;
    wr_n = 1'b1;
    cyc(3);
    cs_n = 1'b1;
    cyc(6);

    // shared bus mode, R3 and R8
    mux_sel = 1'b1;
    ale = 1'b0;
    cyc(4);
    latch_addr(8'h5C);
    host_write(8'h5C, 8'h3E, 8'hE1);
    host_write(8'h5C, 8'h81, 8'h0F);
    host_read(8'h5C, 8'h22);
    latch_addr(8'h9A);
    host_read(8'h9A, 8'h44);
    host_write(8'h9A, 8'h6D, 8'hBB);

    cyc(10);
    check(wr_q.size() == 0, "R2 R3 pending writes", wr_q.size(), 0);
    check(rd_q.size() == 0, "R4 pending reads", rd_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule